// File: doc/BRIEF.md
# USB Endpoint Transaction Status Tracker

This block follows the decoded events of one USB endpoint's transactions and keeps that endpoint's status. A packet decoder upstream supplies the token strobe and its PID, a flag saying whether the token addressed this endpoint, the start of the data packet, the received byte count (CRC bytes included), the CRC verdict, the data PID toggle, whether an ACK handshake was exchanged, and the end-of-transaction strobe. The configured direction of the endpoint decides which tokens it answers.

From these events the block keeps a record of which PID was last seen (SETUP, IN or OUT). It also keeps a data-valid bit, the captured toggle, the received count and an ACK flag, and it pulses an interrupt request to the CPU. A transaction that is not valid leaves every field alone. A data packet corrupted by a bad CRC still interrupts, so that firmware learns the buffer content is damaged.

Top module: `ep_txn_status`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it, every status output and `irq` reads 0.
- R2: A token is accepted only if `tokAddrOk` is 1 and `cfgMode` allows the PID. The `cfgMode` encoding is 0 = disabled (nothing), 1 = OUT only, 2 = IN only, 3 = control (OUT, IN and SETUP). The `tokPid` encoding is 0 = OUT, 1 = IN, 2 = SETUP. A transaction on a token that is not accepted changes no output and raises no `irq`.
- R3: A SETUP token is accepted only when `cfgMode` is 3.
- R4: For an accepted SETUP, `setupFlag` becomes 1 and `inFlag`/`outFlag` become 0 in the cycle after `dataStart`, before the transaction ends.
- R5: `inFlag` or `outFlag` is set, with the other two PID flags cleared, in the cycle after `txnEnd` of a valid IN or OUT transaction. At most one of the three PID flags is ever 1.
- R6: An accepted OUT or SETUP whose `crcOk` is 1 and whose `dataCount` is below EP_SIZE+2 (10 by default) is valid. One cycle after `txnEnd` it shows `dataValid`=1, `rxCount`=`dataCount`, `toggle`=`dataTog`, and an `irq` pulse.
- R7: An accepted OUT or SETUP with a good CRC but `dataCount` of EP_SIZE+2 or more is ignored at its end: no `irq`, and no change to count, data-valid, toggle, ACK or IN/OUT flags. A SETUP flag already set at its data start stays set.
- R8: An accepted OUT or SETUP with `crcOk`=0 is a corruption. One cycle after `txnEnd` it shows `irq` pulsed, `dataValid`=0 and `rxCount`=`dataCount`. `toggle` and the IN/OUT flags are unchanged.
- R9: `irq` is high for exactly the one cycle after the qualifying `txnEnd`.
- R10: `ackFlag` takes the value of `ackSeen` at the end of every transaction that raises `irq`. Ignored transactions leave it unchanged.
- R11: A valid IN transaction raises `irq` and sets `inFlag`, and leaves `dataValid`, `rxCount` and `toggle` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Endpoint direction configuration |
| tokStb | input | 1 | Token decoded this cycle |
| tokPid | input | 2 | Token PID of the decoded token |
| tokAddrOk | input | 1 | Token addressed this endpoint |
| dataStart | input | 1 | Data packet phase begins |
| dataTog | input | 1 | Toggle of the received data packet |
| dataCount | input | CNT_W | Received bytes including CRC bytes |
| crcOk | input | 1 | Data packet CRC passed |
| ackSeen | input | 1 | ACK handshake exchanged |
| txnEnd | input | 1 | Transaction end strobe |
| setupFlag | output | 1 | Last PID was SETUP |
| inFlag | output | 1 | Last PID was IN |
| outFlag | output | 1 | Last PID was OUT |
| dataValid | output | 1 | Last received data valid |
| toggle | output | 1 | Toggle of last valid data |
| rxCount | output | CNT_W | Last received count |
| ackFlag | output | 1 | ACK exchanged in last completed transaction |
| irq | output | 1 | Interrupt request pulse |

## Verification
Every result comes from one register stage. The end-of-transaction fields and `irq` are due one cycle after the `txnEnd` edge. `setupFlag` is due one cycle after the `dataStart` edge, and `irq` must be low again one cycle later. The bench drives inputs on falling edges and samples on the next falling edge after the edge that takes the event. It reads `setupFlag` before raising `txnEnd`, reads all status fields and `irq` on the following falling edge, and confirms `irq` has dropped one cycle after that.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

  typedef enum logic [1:0] {
    PID_OUT   = 2'd0,
    PID_IN    = 2'd1,
    PID_SETUP = 2'd2
  } pidE;

  typedef enum logic [1:0] {
    CFG_OFF  = 2'd0,
    CFG_OUT  = 2'd1,
    CFG_IN   = 2'd2,
    CFG_CTRL = 2'd3
  } cfgE;

  // strobes from control to datapath
  typedef struct packed {
    logic setSetup;
    logic setIn;
    logic setOut;
    logic loadData;
    logic dataGood;
    logic loadAck;
  } epStrobeT;

endpackage

// File: rtl/ep_status_ctrl.sv
module ep_status_ctrl
  import ep_status_pkg::*;
#(
  parameter int EP_SIZE = 8,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             tokStb,
  input  logic [1:0]       tokPid,
  input  logic             tokAddrOk,
  input  logic             dataStart,
  input  logic             txnEnd,
  input  logic             crcOk,
  input  logic [CNT_W-1:0] dataCount,
  output epStrobeT         stb,
  output logic             irq
);

  localparam logic [CNT_W:0] LIMIT_V = (CNT_W+1)'(EP_SIZE + 2);

  logic       active;
  logic [1:0] curPid;
  logic       accept;
  logic       sizeOk;
  logic       isData;
  logic       endGood;
  logic       endCorrupt;

  always_comb begin
    unique case (cfgE'(cfgMode))
      CFG_OUT:  accept = (tokPid == PID_OUT);
      CFG_IN:   accept = (tokPid == PID_IN);
      CFG_CTRL: accept = (tokPid != 2'd3);
      default:  accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      curPid <= PID_OUT;
    end else if (tokStb) begin
      active <= tokAddrOk && accept;
      curPid <= tokPid;
    end else if (txnEnd) begin
      active <= 1'b0;
    end
  end

  always_comb begin
    sizeOk     = ({1'b0, dataCount} < LIMIT_V);
    isData     = (curPid != PID_IN);
    endGood    = active && txnEnd && (!isData || (crcOk && sizeOk));
    endCorrupt = active && txnEnd && isData && !crcOk;

    stb.setSetup = active && dataStart && (curPid == PID_SETUP);
    stb.setIn    = endGood && (curPid == PID_IN);
    stb.setOut   = endGood && (curPid == PID_OUT);
    stb.loadData = (endGood || endCorrupt) && isData;
    stb.dataGood = endGood;
    stb.loadAck  = endGood || endCorrupt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= endGood || endCorrupt;
  end

  // R2
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !irq);

  // R3
  setup_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokStb && cfgMode != CFG_CTRL && tokPid == PID_SETUP) |=> !active);

endmodule

// File: rtl/ep_status_dp.sv
module ep_status_dp
  import ep_status_pkg::*;
#(
  parameter int EP_SIZE = 8,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  epStrobeT         stb,
  input  logic [CNT_W-1:0] dataCount,
  input  logic             dataTog,
  input  logic             ackSeen,
  output logic             setupFlag,
  output logic             inFlag,
  output logic             outFlag,
  output logic             dataValid,
  output logic             toggle,
  output logic [CNT_W-1:0] rxCount,
  output logic             ackFlag
);

  localparam logic [CNT_W:0] LIMIT_V = (CNT_W+1)'(EP_SIZE + 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupFlag <= 1'b0;
      inFlag    <= 1'b0;
      outFlag   <= 1'b0;
    end else if (stb.setSetup || stb.setIn || stb.setOut) begin
      setupFlag <= stb.setSetup;
      inFlag    <= stb.setIn;
      outFlag   <= stb.setOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      toggle    <= 1'b0;
      rxCount   <= '0;
    end else if (stb.loadData) begin
      dataValid <= stb.dataGood;
      rxCount   <= dataCount;
      if (stb.dataGood) toggle <= dataTog;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ackFlag <= 1'b0;
    else if (stb.loadAck) ackFlag <= ackSeen;
  end

  // R5
  pid_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setupFlag, inFlag, outFlag}));

  // R6
  valid_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ({1'b0, rxCount} < LIMIT_V));

endmodule

// File: rtl/ep_txn_status.sv
module ep_txn_status
  import ep_status_pkg::*;
#(
  parameter int EP_SIZE = 8,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             tokStb,
  input  logic [1:0]       tokPid,
  input  logic             tokAddrOk,
  input  logic             dataStart,
  input  logic             dataTog,
  input  logic [CNT_W-1:0] dataCount,
  input  logic             crcOk,
  input  logic             ackSeen,
  input  logic             txnEnd,
  output logic             setupFlag,
  output logic             inFlag,
  output logic             outFlag,
  output logic             dataValid,
  output logic             toggle,
  output logic [CNT_W-1:0] rxCount,
  output logic             ackFlag,
  output logic             irq
);

  epStrobeT stb;

  ep_status_ctrl #(.EP_SIZE(EP_SIZE), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .tokStb(tokStb),
    .tokPid(tokPid), .tokAddrOk(tokAddrOk), .dataStart(dataStart),
    .txnEnd(txnEnd), .crcOk(crcOk), .dataCount(dataCount),
    .stb(stb), .irq(irq)
  );

  ep_status_dp #(.EP_SIZE(EP_SIZE), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataCount(dataCount),
    .dataTog(dataTog), .ackSeen(ackSeen), .setupFlag(setupFlag),
    .inFlag(inFlag), .outFlag(outFlag), .dataValid(dataValid),
    .toggle(toggle), .rxCount(rxCount), .ackFlag(ackFlag)
  );

  // R4
  setup_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setupFlag) |-> $past(dataStart));

  // R5
  in_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFlag) |-> $past(txnEnd));

endmodule

// File: tb/test_ep_txn_status.sv
module test_ep_txn_status;

  localparam int CNT_W = 6;
  localparam int NVEC  = 13;

  typedef struct packed {
    logic [1:0]       cfg;
    logic [1:0]       pid;
    logic             addr;
    logic [CNT_W-1:0] cnt;
    logic             crc;
    logic             tog;
    logic             ack;
    logic             eIrq;
    logic             eS;
    logic             eI;
    logic             eO;
    logic             eDv;
    logic             eTg;
    logic [CNT_W-1:0] eCnt;
    logic             eAck;
  } vecT;

  // cfg pid addr cnt crc tog ack | irq S I O dv tg cnt ack
  localparam vecT VECS [NVEC] = '{
    '{2'd1, 2'd0, 1'b1, 6'd6,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd6,  1'b1}, // R6 R5
    '{2'd1, 2'd1, 1'b1, 6'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd6,  1'b1}, // R2
    '{2'd2, 2'd1, 1'b1, 6'd2,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd6,  1'b1}, // R11
    '{2'd2, 2'd0, 1'b1, 6'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd6,  1'b1}, // R2
    '{2'd3, 2'd2, 1'b1, 6'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd6,  1'b1}, // R7
    '{2'd3, 2'd0, 1'b1, 6'd9,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd9,  1'b1}, // R6
    '{2'd3, 2'd0, 1'b1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5,  1'b0}, // R8
    '{2'd1, 2'd2, 1'b1, 6'd4,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5,  1'b0}, // R3
    '{2'd3, 2'd2, 1'b1, 6'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2,  1'b1}, // R6
    '{2'd3, 2'd0, 1'b0, 6'd7,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2,  1'b1}, // R2
    '{2'd0, 2'd1, 1'b1, 6'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2,  1'b1}, // R2
    '{2'd3, 2'd1, 1'b1, 6'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd2,  1'b0}, // R10 R11
    '{2'd3, 2'd2, 1'b1, 6'd8,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd8,  1'b0}  // R8
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       cfgMode;
  logic             tokStb;
  logic [1:0]       tokPid;
  logic             tokAddrOk;
  logic             dataStart;
  logic             dataTog;
  logic [CNT_W-1:0] dataCount;
  logic             crcOk;
  logic             ackSeen;
  logic             txnEnd;
  logic             setupFlag, inFlag, outFlag, dataValid, toggle, ackFlag, irq;
  logic [CNT_W-1:0] rxCount;

  int nChecks = 0;
  int nErr    = 0;
  string tags [NVEC];

  always #5 clk = ~clk;

  ep_txn_status #(.EP_SIZE(8), .CNT_W(CNT_W)) i_ep_txn_status (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .tokStb(tokStb),
    .tokPid(tokPid), .tokAddrOk(tokAddrOk), .dataStart(dataStart),
    .dataTog(dataTog), .dataCount(dataCount), .crcOk(crcOk),
    .ackSeen(ackSeen), .txnEnd(txnEnd), .setupFlag(setupFlag),
    .inFlag(inFlag), .outFlag(outFlag), .dataValid(dataValid),
    .toggle(toggle), .rxCount(rxCount), .ackFlag(ackFlag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkAllZero(input string tag);
    chk(tag, {24'd0, setupFlag, inFlag, outFlag, dataValid, toggle, ackFlag, irq}, 32'd0);
    chk(tag, 32'(rxCount), 32'd0);
  endtask

  task automatic runVec(input vecT v, input string tag, input logic prevS);
    logic expMid;
    @(negedge clk);
    cfgMode = v.cfg; tokPid = v.pid; tokAddrOk = v.addr; tokStb = 1'b1;
    @(negedge clk);
    tokStb = 1'b0; tokAddrOk = 1'b0; dataStart = (v.pid != 2'd1);
    @(negedge clk);
    dataStart = 1'b0;
    expMid = (v.cfg == 2'd3 && v.addr && v.pid == 2'd2) ? 1'b1 : prevS;
    chk({"R4 ", tag}, 32'(setupFlag), 32'(expMid));
    txnEnd = 1'b1; dataCount = v.cnt; crcOk = v.crc; dataTog = v.tog; ackSeen = v.ack;
    @(negedge clk);
    txnEnd = 1'b0;
    chk({"R9 irq ", tag}, 32'(irq), 32'(v.eIrq));
    chk({"R5 pid flags ", tag}, {29'd0, setupFlag, inFlag, outFlag}, {29'd0, v.eS, v.eI, v.eO});
    chk({"data fields ", tag}, {30'd0, dataValid, toggle}, {30'd0, v.eDv, v.eTg});
    chk({"count ", tag}, 32'(rxCount), 32'(v.eCnt));
    chk({"R10 ack ", tag}, 32'(ackFlag), 32'(v.eAck));
    @(negedge clk);
    chk({"R9 irq drop ", tag}, 32'(irq), 32'd0);
  endtask

  initial begin
    tags = '{"v0 R6 R5", "v1 R2", "v2 R11", "v3 R2", "v4 R7", "v5 R6",
             "v6 R8", "v7 R3", "v8 R6", "v9 R2", "v10 R2", "v11 R10 R11", "v12 R8"};
    rstN = 1'b0; cfgMode = 2'd0; tokStb = 1'b0; tokPid = 2'd0; tokAddrOk = 1'b0;
    dataStart = 1'b0; dataTog = 1'b0; dataCount = '0; crcOk = 1'b0;
    ackSeen = 1'b0; txnEnd = 1'b0;
    repeat (3) @(negedge clk);
    chkAllZero("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    chkAllZero("R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      runVec(VECS[i], tags[i], (i == 0) ? 1'b0 : VECS[i-1].eS);
    end

    // R1: reset in the middle of operation clears the recorded state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chkAllZero("R1 mid-run reset");
    rstN = 1'b1;
    @(negedge clk);
    chkAllZero("R1 mid-run release");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #(100000 * 10);
    nChecks++;
    nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule